// File: doc/BRIEF.md
# Memory-Region Hazard Scoreboard

This block lets a processor keep executing while an attached array coprocessor works on shared memory, and keeps the combined result identical to running everything in program order. Each coprocessor operation names a memory block it reads and a memory block it writes. Each block is a base address plus a size of two to the power `lg` bytes. When the operation is issued, both blocks are recorded in a small table of outstanding operations, and the operation is given an entry index.

Every later processor load or store, and every later coprocessor issue, is compared against the blocks that are still outstanding. A conflicting request is held by a stall output until the owning operation reports completion with its entry index. A stall caused by that entry drops in the cycle after the completion is presented. Between operations, the table holds only the outstanding blocks. The memory and the coprocessor datapath sit outside the block.

Top module: `region_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, no operation is outstanding. No access stalls, and the first issue is accepted at entry index 0.
- R2: An accepted issue (`iss_valid` high and `iss_stall` low) takes the lowest-numbered free entry, and `iss_idx` shows that index in the same cycle.
- R3: When all `N_ENT` (default 4) entries are outstanding, an issue stalls even if its blocks are disjoint from all others.
- R4: A load (`acc_store`=0) stalls exactly when its address lies inside the write block of some outstanding operation. A load inside a read block only does not stall.
- R5: A store (`acc_store`=1) stalls when its address lies inside the read block or the write block of some outstanding operation.
- R6: A block of size 2^lg covers the addresses whose bits above bit lg-1 equal those of the base. The low lg bits of a supplied base are ignored. The address just past the block's end does not stall.
- R7: An issue stalls if its write block overlaps an outstanding read or write block, or if its read block overlaps an outstanding write block. Overlap between two read blocks alone does not stall.
- R8: A completion (`cmp_valid` with `cmp_idx`) frees that entry at the clock edge. Stalls due to it are still present in the completion cycle and are gone in the next cycle. A completion naming a free entry changes nothing.
- R9: `acc_stall` is low whenever `acc_valid` is low. `iss_stall` is low whenever `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Coprocessor operation presented for issue |
| iss_src_addr | input | 32 | Base address of the block the operation reads |
| iss_src_lg | input | 6 | log2 of the read block size |
| iss_dst_addr | input | 32 | Base address of the block the operation writes |
| iss_dst_lg | input | 6 | log2 of the write block size |
| iss_stall | output | 1 | Issue must be held this cycle |
| iss_idx | output | 2 | Entry index given to an accepted issue |
| cmp_valid | input | 1 | A coprocessor operation has finished |
| cmp_idx | input | 2 | Entry index of the finished operation |
| acc_valid | input | 1 | Processor memory access presented for checking |
| acc_addr | input | 32 | Byte address of the access |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_stall | output | 1 | Access must be held this cycle |

## Verification
Directed patterns place loads and stores inside write blocks, inside read blocks, and one byte past a block's end. These separate the load and store rules from each other and catch off-by-one masking. Unaligned bases show whether the low bits are discarded. Issues with read-on-read, read-on-write and write-on-read overlap separate true hazards from harmless sharing. A filled table tells the capacity stall apart from a conflict stall. Completions of busy entries, of free entries, and completions in the same cycle as an issue expose ordering errors. A behavioural model then checks long random mixes of these.

// File: rtl/rsb_pkg.sv
// Shared types and helpers for the memory-region hazard scoreboard.
// Assumes byte addresses and power-of-two block sizes given as log2.
package rsb_pkg;
    localparam int ADDR_W = 32;
    localparam int LG_W   = 6;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LG_W-1:0]   lg;
    } region_t;

    // Mask keeping the address bits above a block of size 2^lg.
    function automatic logic [ADDR_W-1:0] block_mask(input logic [LG_W-1:0] lg);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i >= int'(lg));
        end
        return m;
    endfunction

    // Clear the offset bits of a block base.
    function automatic region_t align_region(input region_t r);
        region_t o;
        o      = r;
        o.base = r.base & block_mask(r.lg);
        return o;
    endfunction
endpackage

// File: rtl/rsb_region_match.sv
// Overlap test for two aligned power-of-two blocks.
// Two such blocks overlap exactly when they agree above the larger block's offset.
// Assumes nothing about the alignment of the inputs; the mask discards low bits.
module rsb_region_match
    import rsb_pkg::*;
(
    input  region_t a,
    input  region_t b,
    output logic    hit
);
    logic [LG_W-1:0]   lg_max;
    logic [ADDR_W-1:0] mask;

    // Compare high address bits under the mask of the larger block.
    always_comb begin
        lg_max = (a.lg > b.lg) ? a.lg : b.lg;
        mask   = block_mask(lg_max);
        hit    = ((a.base ^ b.base) & mask) == '0;
    end
endmodule

// File: rtl/rsb_alloc.sv
// Lowest-index free-entry finder for the outstanding-operation table.
// Assumes N_ENT is at least 2.
module rsb_alloc #(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] valid,
    output logic [IDX_W-1:0] free_idx,
    output logic             any_free
);
    // Scan from the top down so that the lowest free entry wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsb_table.sv
// Storage for outstanding coprocessor operations: valid bit, read block, write block.
// Bases are aligned as they are written. A free of an idle entry is harmless.
// Assumes the allocator never picks an entry that is already valid.
module rsb_table
    import rsb_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  region_t          alloc_src,
    input  region_t          alloc_dst,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    output logic [N_ENT-1:0] valid_q,
    output region_t          src_q [N_ENT],
    output region_t          dst_q [N_ENT]
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic sel_alloc;
        logic sel_free;
        assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(g));
        assign sel_free  = free_en  && (free_idx  == IDX_W'(g));

        // Track whether this entry holds an outstanding operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (sel_alloc) begin
                valid_q[g] <= 1'b1;
            end else if (sel_free) begin
                valid_q[g] <= 1'b0;
            end
        end

        // Capture the aligned blocks of a newly issued operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g] <= '0;
                dst_q[g] <= '0;
            end else if (sel_alloc) begin
                src_q[g] <= align_region(alloc_src);
                dst_q[g] <= align_region(alloc_dst);
            end
        end
    end
endmodule

// File: rtl/rsb_hazard.sv
// Per-entry hazard detection for processor accesses and new coprocessor issues.
// A load conflicts with write blocks. A store conflicts with read and write blocks.
// An issue conflicts on write-after-read, write-after-write and read-after-write.
module rsb_hazard
    import rsb_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic [N_ENT-1:0]  valid,
    input  region_t           src_q [N_ENT],
    input  region_t           dst_q [N_ENT],
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    input  logic              iss_valid,
    input  region_t           iss_src,
    input  region_t           iss_dst,
    output logic              acc_hit,
    output logic              iss_hit
);
    region_t           acc_r;
    logic [N_ENT-1:0]  acc_hit_v;
    logic [N_ENT-1:0]  iss_hit_v;

    // A single byte access is a block of size one.
    always_comb begin
        acc_r.base = acc_addr;
        acc_r.lg   = '0;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic h_acc_src, h_acc_dst, h_wr_src, h_wr_dst, h_rd_dst;

        rsb_region_match u_acc_src (.a(acc_r),   .b(src_q[g]), .hit(h_acc_src));
        rsb_region_match u_acc_dst (.a(acc_r),   .b(dst_q[g]), .hit(h_acc_dst));
        rsb_region_match u_wr_src  (.a(iss_dst), .b(src_q[g]), .hit(h_wr_src));
        rsb_region_match u_wr_dst  (.a(iss_dst), .b(dst_q[g]), .hit(h_wr_dst));
        rsb_region_match u_rd_dst  (.a(iss_src), .b(dst_q[g]), .hit(h_rd_dst));

        // Combine this entry's overlaps under the access and issue rules.
        always_comb begin
            acc_hit_v[g] = valid[g] && (h_acc_dst || (acc_store && h_acc_src));
            iss_hit_v[g] = valid[g] && (h_wr_src || h_wr_dst || h_rd_dst);
        end
    end

    // Reduce the per-entry conflicts, gated by the request strobes.
    always_comb begin
        acc_hit = acc_valid && (|acc_hit_v);
        iss_hit = iss_valid && (|iss_hit_v);
    end
endmodule

// File: rtl/region_scoreboard.sv
// Memory-region hazard scoreboard, top level.
// Records the read and write blocks of each issued coprocessor operation.
// Stalls conflicting processor accesses and issues until completion.
// Assumes completions name entries handed out by iss_idx. Stalls are combinational
// from registered state, so a completion releases in the following cycle.
module region_scoreboard
    import rsb_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_src_addr,
    input  logic [LG_W-1:0]   iss_src_lg,
    input  logic [ADDR_W-1:0] iss_dst_addr,
    input  logic [LG_W-1:0]   iss_dst_lg,
    output logic              iss_stall,
    output logic [IDX_W-1:0]  iss_idx,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    output logic              acc_stall
);
    region_t          iss_src, iss_dst;
    logic [N_ENT-1:0] valid_q;
    region_t          src_q [N_ENT];
    region_t          dst_q [N_ENT];
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic             acc_hit, iss_hit, accept;

    // Pack the issue request into block descriptors.
    always_comb begin
        iss_src.base = iss_src_addr;
        iss_src.lg   = iss_src_lg;
        iss_dst.base = iss_dst_addr;
        iss_dst.lg   = iss_dst_lg;
    end

    rsb_alloc #(.N_ENT(N_ENT)) u_alloc (
        .valid    (valid_q),
        .free_idx (free_idx),
        .any_free (any_free)
    );

    rsb_hazard #(.N_ENT(N_ENT)) u_haz (
        .valid     (valid_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_store (acc_store),
        .iss_valid (iss_valid),
        .iss_src   (iss_src),
        .iss_dst   (iss_dst),
        .acc_hit   (acc_hit),
        .iss_hit   (iss_hit)
    );

    // Decide stalls and acceptance from the current table contents.
    always_comb begin
        iss_stall = iss_valid && (!any_free || iss_hit);
        accept    = iss_valid && !iss_stall;
        iss_idx   = free_idx;
        acc_stall = acc_hit;
    end

    rsb_table #(.N_ENT(N_ENT)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (accept),
        .alloc_idx (free_idx),
        .alloc_src (iss_src),
        .alloc_dst (iss_dst),
        .free_en   (cmp_valid),
        .free_idx  (cmp_idx),
        .valid_q   (valid_q),
        .src_q     (src_q),
        .dst_q     (dst_q)
    );
endmodule

// File: rtl/rsb_checker.sv
// Protocol and state checks for the region scoreboard, bound to the top module.
module rsb_checker #(
    parameter int N_ENT = 4,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_stall,
    input logic [IDX_W-1:0] iss_idx,
    input logic             cmp_valid,
    input logic [IDX_W-1:0] cmp_idx,
    input logic             acc_valid,
    input logic             acc_stall,
    input logic [N_ENT-1:0] valid_q
);
    p_empty_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q == '0) |-> !acc_stall);

    p_alloc_is_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall) |-> !valid_q[iss_idx]);

    p_alloc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall) |=> valid_q[$past(iss_idx)]);

    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && ($countones(valid_q) == N_ENT)) |-> iss_stall);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !(iss_valid && !iss_stall && iss_idx == cmp_idx))
        |=> !valid_q[$past(cmp_idx)]);

    p_idle_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_stall);

    p_idle_iss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !iss_stall);
endmodule

bind region_scoreboard rsb_checker #(.N_ENT(N_ENT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_stall (iss_stall),
    .iss_idx   (iss_idx),
    .cmp_valid (cmp_valid),
    .cmp_idx   (cmp_idx),
    .acc_valid (acc_valid),
    .acc_stall (acc_stall),
    .valid_q   (valid_q)
);

// File: tb/tb_region_scoreboard.sv
// Self-checking bench: a behavioural model with interval arithmetic is compared every cycle.
module tb_region_scoreboard;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [31:0] iss_src_addr = '0;
    logic [5:0]  iss_src_lg = '0;
    logic [31:0] iss_dst_addr = '0;
    logic [5:0]  iss_dst_lg = '0;
    logic        iss_stall;
    logic [1:0]  iss_idx;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_idx = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_store = 1'b0;
    logic        acc_stall;

    int errors = 0;
    int checks = 0;

    bit     mv [N];
    longint ms_b [N], ms_e [N], md_b [N], md_e [N];

    always #10 clk = ~clk;

    region_scoreboard #(.N_ENT(N)) dut (.*);

    function automatic longint lo(longint a, int lg);
        longint sz = longint'(1) << lg;
        return a - (a % sz);
    endfunction

    function automatic longint hi(longint a, int lg);
        return lo(a, lg) + (longint'(1) << lg);
    endfunction

    function automatic bit ov(longint a0, longint a1, longint b0, longint b1);
        return (a0 < b1) && (b0 < a1);
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare combinational outputs, clock, update the model.
    task automatic step(input bit iv, input longint sa, input int sl, input longint da, input int dl,
                        input bit cv, input int ci, input bit av, input longint aa, input bit ast,
                        input string what);
        bit e_acc, e_iss, full, acc_ok;
        int lowfree;
        @(negedge clk);
        iss_valid = iv; iss_src_addr = 32'(sa); iss_src_lg = 6'(sl);
        iss_dst_addr = 32'(da); iss_dst_lg = 6'(dl);
        cmp_valid = cv; cmp_idx = 2'(ci);
        acc_valid = av; acc_addr = 32'(aa); acc_store = ast;
        #2;
        e_acc = 1'b0; e_iss = 1'b0; lowfree = -1;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) lowfree = i;
        full = (lowfree < 0);
        for (int i = 0; i < N; i++) begin
            if (mv[i]) begin
                if (ov(aa, aa + 1, md_b[i], md_e[i])) e_acc = 1'b1;
                if (ast && ov(aa, aa + 1, ms_b[i], ms_e[i])) e_acc = 1'b1;
                if (ov(lo(da, dl), hi(da, dl), ms_b[i], ms_e[i])) e_iss = 1'b1;
                if (ov(lo(da, dl), hi(da, dl), md_b[i], md_e[i])) e_iss = 1'b1;
                if (ov(lo(sa, sl), hi(sa, sl), md_b[i], md_e[i])) e_iss = 1'b1;
            end
        end
        e_acc = av && e_acc;
        e_iss = iv && (full || e_iss);
        acc_ok = acc_stall;
        chk(acc_ok, e_acc, ast ? "R5" : "R4", {what, " acc_stall"});
        chk(iss_stall, e_iss, full ? "R3" : "R7", {what, " iss_stall"});
        if (iv && !e_iss) begin
            checks++;
            if (int'(iss_idx) != lowfree) begin
                errors++;
                $display("FAIL R2 %s iss_idx: actual=%0d expected=%0d", what, iss_idx, lowfree);
            end
        end
        @(posedge clk);
        #1;
        if (iv && !e_iss) begin
            mv[lowfree] = 1'b1;
            ms_b[lowfree] = lo(sa, sl); ms_e[lowfree] = hi(sa, sl);
            md_b[lowfree] = lo(da, dl); md_e[lowfree] = hi(da, dl);
        end
        if (cv && !(iv && !e_iss && lowfree == ci)) mv[ci] = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: idle after reset, first issue at index 0
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h2010, 1, "R1 idle store");
        step(1, 'h1000, 8, 'h2000, 8, 0, 0, 1, 'h2010, 0, "R1 first issue");
        // R4: loads against write and read blocks
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h2010, 0, "R4 load in dst");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h1010, 0, "R4 load in src");
        // R6: one past end and one before start
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h2100, 1, "R6 past end");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h1FFF, 0, "R6 before start");
        // R5: stores hit both blocks
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h1010, 1, "R5 store in src");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h20FF, 1, "R5 store in dst");
        // R6: unaligned bases are truncated
        step(1, 'h3004, 4, 'h4007, 4, 0, 0, 0, 0, 0, "R6 unaligned issue");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h4000, 0, "R6 aligned start");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h4010, 0, "R6 aligned end");
        // R7: read-after-write, harmless read sharing, write-after-read
        step(1, 'h2040, 4, 'h5000, 4, 0, 0, 0, 0, 0, "R7 raw issue");
        step(1, 'h1000, 12, 'h8000, 4, 0, 0, 0, 0, 0, "R7 read share");
        step(1, 'h9000, 4, 'h1800, 4, 0, 0, 0, 0, 0, "R7 war issue");
        step(1, 'h9000, 4, 'hA000, 4, 0, 0, 0, 0, 0, "R2 fourth entry");
        // R3: full table
        step(1, 'hC000, 4, 'hD000, 4, 0, 0, 0, 0, 0, "R3 full");
        // R8: release timing
        step(0, 0, 0, 0, 0, 1, 1, 1, 'h4000, 0, "R8 completion cycle");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h4000, 0, "R8 after completion");
        step(0, 0, 0, 0, 0, 1, 1, 1, 'h2010, 0, "R8 free entry completion");
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h2010, 0, "R8 state kept");
        step(1, 'hC000, 4, 'hD000, 4, 0, 0, 0, 0, 0, "R2 reuse lowest");
        // R9: strobes low
        step(0, 'h2000, 4, 'h2000, 4, 0, 0, 0, 'h2010, 1, "R9 strobes low");
        // R8/R2: completion and issue in the same cycle
        step(1, 'hE000, 4, 'hF000, 4, 1, 0, 0, 0, 0, "R8 same-cycle full");
        step(1, 'h2000, 4, 'hF100, 4, 0, 0, 1, 'h2000, 1, "R2 after free");
        // Random mix over a small address space
        for (int k = 0; k < 400; k++) begin
            int  sl = int'($urandom_range(2, 9));
            int  dl = int'($urandom_range(2, 9));
            longint sa = longint'($urandom_range(0, 63)) << 6;
            longint da = longint'($urandom_range(0, 63)) << 6;
            longint aa = longint'($urandom_range(0, 4095));
            int ci = int'($urandom_range(0, N - 1));
            step(bit'($urandom_range(0, 1)), sa + 3, sl, da + 1, dl,
                 ($urandom_range(0, 2) == 0), ci,
                 bit'($urandom_range(0, 1)), aa, bit'($urandom_range(0, 1)), "random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule